// File: doc/BRIEF.md
# Time-Slot Bus Arbiter with Round-Robin Reclaim

This block decides which of several initiators may use a shared interconnect during each slot of a repeating slot wheel. A programmable table holds one entry per slot. Each entry either reserves the slot for one initiator or leaves it open. Reserved slots give their owner a guaranteed share of bandwidth. The owner keeps a right of refusal: when it is not requesting at the start of its slot, the slot is not wasted and goes to another requester. Open slots and refused slots are handed out round-robin, so non-critical traffic gets a fair share of whatever the reserved traffic leaves.

Each slot lasts a fixed number of bus clocks. The grant is decided at the slot boundary and held for the whole slot. After a grant, a programmable delay of 2 to 7 clocks passes, and then a one-cycle transfer strobe marks the point at which the granted initiator's transfer takes place. The table is loaded through a single write port while the wheel keeps turning. The delay setting is read once per slot.

Top module: `tdma_rr_arbiter`

## Requirements
- R1: While reset is asserted and right after it, `grant_o` is 0, `grant_idx_o` is 0, `xfer_valid_o` is 0 and `slot_o` is 0. Reset marks every table entry as unowned and points the round-robin search at initiator 0. The first slot decided after reset is slot 0.
- R2: A slot lasts 8 clocks. The decision is taken on the clock edge that ends the previous slot. `slot_o` shows the number of the slot now granted and counts 0 to 15, then wraps. `grant_o` and `grant_idx_o` do not change within a slot.
- R3: When the current slot's entry is owned (used bit 1) and its owner's `req_i` bit is 1 at the decision edge, the owner is granted, whatever the other requests are.
- R4: When the slot is owned but its owner is not requesting, the slot goes to the round-robin choice among the initiators that are requesting.
- R5: When the slot's entry is unowned (used bit 0), the slot goes to the round-robin choice among all requesters.
- R6: The round-robin search starts at the initiator one above the last one that won a round-robin slot, modulo 4, and takes the first requester it finds going upward. Owner grants leave the search start unchanged.
- R7: When no initiator requests at the decision edge, `grant_o` is 0 and `grant_idx_o` is 0 for that slot, no strobe occurs, and the wheel still advances.
- R8: `grant_o` has at most one bit set. When a bit is set, `grant_idx_o` is its index.
- R9: In a granted slot, `xfer_valid_o` is high for exactly one clock, in the slot's clock number L. The slot's first clock is number 0, and L is the latency used for that slot.
- R10: The latency is taken from `lat_i` at the decision edge. Values below 2 are used as 2 and values above 7 are used as 7. A change of `lat_i` within a slot does not affect that slot.
- R11: A write (`cfg_we_i` = 1) stores the used bit `cfg_used_i` and the owner index `cfg_owner_i` into the entry `cfg_slot_i`. The new entry governs every decision taken after the write edge.
- R12: Only the requests present at the decision edge matter. A change of `req_i` within a slot does not change that slot's grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Request bit per initiator |
| lat_i | input | 4 | Grant-to-transfer latency in clocks (clamped to 2..7) |
| cfg_we_i | input | 1 | Slot table write enable |
| cfg_slot_i | input | 4 | Slot table entry to write |
| cfg_used_i | input | 1 | 1 = slot reserved for an owner, 0 = open slot |
| cfg_owner_i | input | 2 | Owner initiator index for the entry |
| grant_o | output | 4 | One-hot grant for the current slot |
| grant_idx_o | output | 2 | Index of the granted initiator (0 when none) |
| xfer_valid_o | output | 1 | One-cycle transfer strobe |
| slot_o | output | 4 | Number of the slot currently granted |

## Verification
The hardest case to reach from the ports is the interplay between the round-robin search start and the owner's right of refusal. The search start moves only on reclaimed or open slots. Its value at any moment therefore depends on the whole history of table contents and request patterns, and it is never visible directly. The stimulus loads a mixed table of owned and open slots. It then steps through wheel turns in which every slot meets every one of the 16 request patterns, in a rotating order, so that refusals, owner wins and open-slot grants interleave in many sequences. A midway table rewrite and mid-slot request and latency changes probe R10, R11 and R12 in the same runs.

// File: rtl/tdma_arb_pkg.sv
package tdma_arb_pkg;

  localparam int unsigned DEF_INITS    = 4;
  localparam int unsigned DEF_SLOTS    = 16;
  localparam int unsigned DEF_SLOT_CYC = 8;
  localparam int unsigned DEF_LAT_MIN  = 2;
  localparam int unsigned DEF_LAT_MAX  = 7;
  localparam int unsigned DEF_LAT_W    = 4;

  // Limit a value to the closed range [lo, hi].
  function automatic int unsigned clamp_range(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Increment with wrap at n.
  function automatic int unsigned wrap_next(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/tdma_slot_map.sv
module tdma_slot_map #(
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned SLOT_W = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_used,
  input  logic [IDX_W-1:0]  wr_owner,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_used,
  output logic [IDX_W-1:0]  rd_owner
);

  logic [N_SLOT-1:0] used_q;
  logic [IDX_W-1:0]  owner_q [N_SLOT];

  for (genvar s = 0; s < N_SLOT; s++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_slot == SLOT_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q[s]  <= 1'b0;
        owner_q[s] <= '0;
      end else if (hit) begin
        used_q[s]  <= wr_used;
        owner_q[s] <= wr_owner;
      end
    end
  end

  assign rd_used  = used_q[rd_slot];
  assign rd_owner = owner_q[rd_slot];

endmodule

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer #(
  parameter int unsigned N_SLOT   = 16,
  parameter int unsigned SLOT_CYC = 8,
  parameter int unsigned SLOT_W   = $clog2(N_SLOT),
  parameter int unsigned PH_W     = $clog2(SLOT_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              decide_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [SLOT_W-1:0] wheel_o
);
  import tdma_arb_pkg::*;

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYC - 1);

  logic [PH_W-1:0]   phase_q;
  logic [SLOT_W-1:0] wheel_q;

  assign decide_o = (phase_q == PH_LAST);
  assign phase_o  = phase_q;
  assign wheel_o  = wheel_q;

  // Reset parks the phase at the last clock so that the first edge decides slot 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LAST;
      wheel_q <= '0;
    end else if (decide_o) begin
      phase_q <= '0;
      wheel_q <= SLOT_W'(wrap_next(int'(wheel_q), N_SLOT));
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/tdma_rr_pick.sv
module tdma_rr_pick #(
  parameter int unsigned N_INIT = 4,
  parameter int unsigned IDX_W  = $clog2(N_INIT)
) (
  input  logic [N_INIT-1:0] req,
  input  logic [IDX_W-1:0]  start,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int off = 0; off < int'(N_INIT); off++) begin
      int unsigned cand;
      cand = (int'(start) + off) % N_INIT;
      if (!found && req[cand]) begin
        found = 1'b1;
        idx   = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/tdma_rr_arbiter.sv
module tdma_rr_arbiter #(
  parameter int unsigned N_INIT   = tdma_arb_pkg::DEF_INITS,
  parameter int unsigned N_SLOT   = tdma_arb_pkg::DEF_SLOTS,
  parameter int unsigned SLOT_CYC = tdma_arb_pkg::DEF_SLOT_CYC,
  parameter int unsigned LAT_MIN  = tdma_arb_pkg::DEF_LAT_MIN,
  parameter int unsigned LAT_MAX  = tdma_arb_pkg::DEF_LAT_MAX,
  parameter int unsigned LAT_W    = tdma_arb_pkg::DEF_LAT_W,
  parameter int unsigned IDX_W    = $clog2(N_INIT),
  parameter int unsigned SLOT_W   = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INIT-1:0] req_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              cfg_we_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic              cfg_used_i,
  input  logic [IDX_W-1:0]  cfg_owner_i,
  output logic [N_INIT-1:0] grant_o,
  output logic [IDX_W-1:0]  grant_idx_o,
  output logic              xfer_valid_o,
  output logic [SLOT_W-1:0] slot_o
);
  import tdma_arb_pkg::*;

  localparam int unsigned PH_W = $clog2(SLOT_CYC);

  // Named internal events, also observed by the bound checker.
  logic              decide_w;
  logic [PH_W-1:0]   phase_w;
  logic [SLOT_W-1:0] wheel_w;
  logic              map_used_w;
  logic [IDX_W-1:0]  map_owner_w;
  logic              own_hit_w;
  logic              rr_found_w;
  logic [IDX_W-1:0]  rr_idx_w;
  logic [PH_W-1:0]   lat_eff_w;

  logic [IDX_W-1:0]  rr_ptr_q;
  logic [IDX_W-1:0]  gnt_idx_q;
  logic              gnt_vld_q;
  logic [PH_W-1:0]   lat_q;
  logic [SLOT_W-1:0] cur_slot_q;

  tdma_slot_timer #(
    .N_SLOT(N_SLOT), .SLOT_CYC(SLOT_CYC), .SLOT_W(SLOT_W), .PH_W(PH_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .decide_o(decide_w), .phase_o(phase_w), .wheel_o(wheel_w)
  );

  tdma_slot_map #(
    .N_SLOT(N_SLOT), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we_i), .wr_slot(cfg_slot_i), .wr_used(cfg_used_i), .wr_owner(cfg_owner_i),
    .rd_slot(wheel_w), .rd_used(map_used_w), .rd_owner(map_owner_w)
  );

  tdma_rr_pick #(
    .N_INIT(N_INIT), .IDX_W(IDX_W)
  ) u_rr (
    .req(req_i), .start(rr_ptr_q), .found(rr_found_w), .idx(rr_idx_w)
  );

  assign own_hit_w = map_used_w && req_i[map_owner_w];
  assign lat_eff_w = PH_W'(clamp_range(int'(lat_i), LAT_MIN, LAT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr_q   <= '0;
      gnt_idx_q  <= '0;
      gnt_vld_q  <= 1'b0;
      lat_q      <= PH_W'(LAT_MIN);
      cur_slot_q <= '0;
    end else if (decide_w) begin
      cur_slot_q <= wheel_w;
      lat_q      <= lat_eff_w;
      if (own_hit_w) begin
        gnt_vld_q <= 1'b1;
        gnt_idx_q <= map_owner_w;
      end else if (rr_found_w) begin
        gnt_vld_q <= 1'b1;
        gnt_idx_q <= rr_idx_w;
        rr_ptr_q  <= IDX_W'(wrap_next(int'(rr_idx_w), N_INIT));
      end else begin
        gnt_vld_q <= 1'b0;
        gnt_idx_q <= '0;
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (gnt_vld_q) grant_o[gnt_idx_q] = 1'b1;
  end

  assign grant_idx_o  = gnt_idx_q;
  assign xfer_valid_o = gnt_vld_q && (phase_w == lat_q);
  assign slot_o       = cur_slot_q;

endmodule

// File: rtl/tdma_rr_arbiter_chk.sv
module tdma_rr_arbiter_chk #(
  parameter int unsigned N_INIT  = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned SLOT_W  = 4,
  parameter int unsigned PH_W    = 3,
  parameter int unsigned LAT_MIN = 2,
  parameter int unsigned LAT_MAX = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_INIT-1:0] req_i,
  input logic [N_INIT-1:0] grant_o,
  input logic [IDX_W-1:0]  grant_idx_o,
  input logic              xfer_valid_o,
  input logic [SLOT_W-1:0] slot_o,
  input logic              decide_w,
  input logic [SLOT_W-1:0] wheel_w,
  input logic              map_used_w,
  input logic [IDX_W-1:0]  map_owner_w,
  input logic [PH_W-1:0]   lat_q
);

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_idx_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> grant_o[grant_idx_o]);

  assert_hold_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !decide_w |=> ($stable(grant_o) && $stable(slot_o)));

  assert_wheel_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    decide_w |=> (slot_o == $past(wheel_w)));

  assert_owner_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_w && map_used_w && req_i[map_owner_w]) |=> (grant_o == (N_INIT'(1) << $past(map_owner_w))));

  assert_idle_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_w && req_i == '0) |=> (grant_o == '0));

  assert_strobe_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> (grant_o != '0));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |=> !xfer_valid_o);

  assert_lat_bounds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> (int'(lat_q) >= LAT_MIN && int'(lat_q) <= LAT_MAX));

endmodule

bind tdma_rr_arbiter tdma_rr_arbiter_chk #(
  .N_INIT(N_INIT), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .PH_W(PH_W),
  .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .grant_o(grant_o),
  .grant_idx_o(grant_idx_o), .xfer_valid_o(xfer_valid_o), .slot_o(slot_o),
  .decide_w(decide_w), .wheel_w(wheel_w), .map_used_w(map_used_w),
  .map_owner_w(map_owner_w), .lat_q(lat_q)
);

// File: tb/tb_tdma_rr_arbiter.sv
module tb_tdma_rr_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_i = '0;
  logic [3:0] lat_i = '0;
  logic       cfg_we_i = 1'b0;
  logic [3:0] cfg_slot_i = '0;
  logic       cfg_used_i = 1'b0;
  logic [1:0] cfg_owner_i = '0;
  logic [3:0] grant_o;
  logic [1:0] grant_idx_o;
  logic       xfer_valid_o;
  logic [3:0] slot_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Bench model of the table and the round-robin search start.
  bit       m_used  [16];
  bit [1:0] m_owner [16];
  int       m_rr    = 0;
  int       m_slot  = 0;

  always #5 clk = ~clk;

  tdma_rr_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .lat_i(lat_i),
    .cfg_we_i(cfg_we_i), .cfg_slot_i(cfg_slot_i), .cfg_used_i(cfg_used_i),
    .cfg_owner_i(cfg_owner_i), .grant_o(grant_o), .grant_idx_o(grant_idx_o),
    .xfer_valid_o(xfer_valid_o), .slot_o(slot_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (slot %0d)", req, what, act, exp, m_slot);
    end
  endtask

  // One full slot: drive at the negedge before the decision edge, then sample 8 clocks.
  task automatic run_slot(input logic [3:0] req, input logic [3:0] lat, input bit mid_change,
                          input bit do_wr, input int wr_slot, input bit wr_used, input int wr_owner);
    int  e_idx;
    bit  e_vld;
    int  e_lat;
    int  cur;
    string rq;
    cur   = m_slot;
    e_vld = 1'b0;
    e_idx = 0;
    rq    = "R5";
    if (m_used[cur] && req[m_owner[cur]]) begin
      e_vld = 1'b1;
      e_idx = int'(m_owner[cur]);
      rq    = "R3";
    end else begin
      if (m_used[cur]) rq = "R4";
      for (int off = 0; off < 4; off++) begin
        int c;
        c = (m_rr + off) % 4;
        if (!e_vld && req[c]) begin
          e_vld = 1'b1;
          e_idx = c;
        end
      end
      if (e_vld) m_rr = (e_idx + 1) % 4;
      else rq = "R7";
    end
    e_lat = (lat < 2) ? 2 : (lat > 7) ? 7 : int'(lat);
    req_i = req;
    lat_i = lat;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(rq,   "grant_o",      int'(grant_o),     e_vld ? (1 << e_idx) : 0);
      check("R8", "grant_idx_o",  int'(grant_idx_o), e_idx);
      check("R9", "xfer_valid_o", int'(xfer_valid_o), (e_vld && k == e_lat) ? 1 : 0);
      check("R2", "slot_o",       int'(slot_o),      cur);
      if (k == 2 && mid_change) begin
        // R12 / R10: mid-slot changes must not alter this slot.
        req_i = ~req;
        lat_i = lat ^ 4'h5;
      end
      if (k == 3 && do_wr) begin
        // R11: table write in the middle of a slot.
        cfg_we_i    = 1'b1;
        cfg_slot_i  = 4'(wr_slot);
        cfg_used_i  = wr_used;
        cfg_owner_i = 2'(wr_owner);
        m_used[wr_slot]  = wr_used;
        m_owner[wr_slot] = 2'(wr_owner);
      end
      if (k == 4) cfg_we_i = 1'b0;
    end
    m_slot = (m_slot + 1) % 16;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_used[i]  = 1'b0;
      m_owner[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "grant_o",      int'(grant_o), 0);
    check("R1", "grant_idx_o",  int'(grant_idx_o), 0);
    check("R1", "xfer_valid_o", int'(xfer_valid_o), 0);
    check("R1", "slot_o",       int'(slot_o), 0);
    rst_n = 1'b1;

    // R1, R5, R6: unowned table after reset, all requesting -> 0,1,2,3,...
    for (int s = 0; s < 16; s++) run_slot(4'hF, 4'(s), 1'b0, 1'b0, 0, 1'b0, 0);
    // R7, R10: idle and varied patterns, full latency range
    for (int s = 0; s < 16; s++) run_slot(4'(s), 4'(15 - s), s[0], 1'b0, 0, 1'b0, 0);

    // R11: load a mixed table while the wheel turns
    for (int s = 0; s < 16; s++)
      run_slot(4'(s * 7), 4'(s), 1'b0, 1'b1, s, (s % 4) != 3, (s + s / 4) % 4);

    // R3, R4, R5, R6, R12: every slot meets every request pattern
    for (int p = 0; p < 16; p++) begin
      for (int s = 0; s < 16; s++) begin
        bit wr;
        wr = (p == 8) && (s % 3 == 0);
        run_slot(4'((p + s) % 16), 4'((p * 3 + s) % 16), ((p + s) % 5) == 0,
                 wr, (s + 5) % 16, (s % 2) == 0, (s + p) % 4);
      end
    end
    // Second sweep with a different order of patterns
    for (int p = 0; p < 16; p++) begin
      for (int s = 0; s < 16; s++)
        run_slot(4'((p * 5 + s * 3) % 16), 4'((p + s * 5) % 16), ((p * s) % 7) == 1,
                 1'b0, 0, 1'b0, 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule